// File: doc/BRIEF.md
# Keyboard Controller Command Processor

This block is the host-side command engine of a PC-style keyboard controller. The host writes bytes to two ports, a command port and a data port. A command byte either acts at once or arms the engine to wait for the next data byte. Commands that act at once can change the mode byte, set the self-test flag, move the A20 gate, request a system reset, or push a reply byte. An armed engine decides what the next data-port byte does: it may load the mode byte, load the output port, be pushed as a reply on the keyboard or mouse channel, or be forwarded to the mouse. A data byte with nothing armed is forwarded to the keyboard.

Reply bytes leave on a byte-push interface toward an output buffer that lies outside this block. That interface carries a channel flag so the buffer can tell keyboard replies from mouse replies. Bytes meant for the attached devices leave on two valid-strobed byte outputs. The mode, status and output-port bytes are visible as outputs at all times.

The engine is a six-state machine held in the state register. In ST_IDLE nothing is armed. Each of the states ST_WAIT_MODE, ST_WAIT_OUTP, ST_WAIT_KOBUF, ST_WAIT_AOBUF and ST_WAIT_MOUSE remembers one armed command. The state changes in three ways:
- An accepted arming command moves the engine from any state to that command's wait state.
- An accepted data write moves the engine from any state back to ST_IDLE.
- Any other accepted command leaves the state as it is.

Every output is registered. An effect becomes visible in the cycle after the clock edge that accepts the write.

Top module: `kbc_cmd_proc`

## Requirements
- R1: After reset, the outputs hold these values: mode 0x03, status 0x18, output port 0xCF, A20 high, and every strobe low.
- R2: A write is accepted only at a clock edge where `rsp_ready` is high. A write that is not accepted has no effect. When `cmd_we` and `data_we` are both high at the same edge, the command is taken and the data byte is dropped.
- R3: Command 0x20 replies with the mode byte, and command 0xD0 replies with the output-port byte. Both replies use the keyboard channel (`rsp_aux`=0), and `rsp_valid` pulses in the cycle after acceptance.
- R4: Command 0xAA sets status bit 2 and replies 0x55. Commands 0xA9 and 0xAB reply 0x00. Command 0xC0 replies 0x80. Status bit 2 is never cleared except by reset.
- R5: Commands 0xA7 and 0xA8 set and clear mode bit 5. Commands 0xAD and 0xAE set and clear mode bit 4. None of these four commands replies.
- R6: Commands 0x60, 0xD1, 0xD2, 0xD3 and 0xD4 produce no output and arm the engine for the next data write. A later arming command replaces the armed one. A non-arming command leaves the armed one in place.
- R7: A data write is handled according to the armed command, and the engine is then disarmed:
  - 0x60 loads the mode byte.
  - 0xD2 pushes the byte as a reply with `rsp_aux`=0.
  - 0xD3 pushes the byte as a reply with `rsp_aux`=1.
  - 0xD4 pulses `aux_tx_valid` with the byte.
  - With nothing armed, the byte pulses `kbd_tx_valid`.
- R8: A data write under 0xD1 loads the output port. A20 then follows bit 1 of the new value. If bit 0 of the new value is 0, `sys_reset_req` pulses for one cycle.
- R9: Command 0xDF sets output-port bit 1 and raises A20. Command 0xDD clears that bit and lowers A20.
- R10: Any command in 0xF0..0xFF with bit 0 clear pulses `sys_reset_req`. Any command in that range with bit 0 set does nothing. Neither case changes the output port.
- R11: Any other command code pulses `bad_cmd` for one cycle and changes no state.
- R12: At most one of `rsp_valid`, `kbd_tx_valid`, `aux_tx_valid`, `sys_reset_req` and `bad_cmd` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_we | input | 1 | Command-port write strobe |
| data_we | input | 1 | Data-port write strobe |
| wr_byte | input | 8 | Byte written to either port |
| rsp_ready | input | 1 | Reply sink can take a byte; writes are accepted only while high |
| rsp_valid | output | 1 | Reply byte push strobe |
| rsp_byte | output | 8 | Reply byte |
| rsp_aux | output | 1 | Reply channel: 1 = mouse, 0 = keyboard |
| kbd_tx_valid | output | 1 | Byte for the keyboard is valid |
| kbd_tx_byte | output | 8 | Byte for the keyboard |
| aux_tx_valid | output | 1 | Byte for the mouse is valid |
| aux_tx_byte | output | 8 | Byte for the mouse |
| mode_byte | output | 8 | Current mode byte |
| status_byte | output | 8 | Current status flags |
| outport_byte | output | 8 | Current output-port byte |
| a20_gate | output | 1 | A20 gate level |
| sys_reset_req | output | 1 | One-cycle system reset request |
| bad_cmd | output | 1 | One-cycle flag for an unrecognised command |

## Verification
Some properties are checked by assertions on every cycle:
- the strobes are mutually exclusive;
- every reply and reset pulse traces back to a write that was accepted;
- the mode byte holds still when a write is refused;
- A20 agrees with output-port bit 1;
- the self-test flag never falls.

Other behaviour can only be shown by the bench's scenarios, where a behavioural model is compared with the design on every clock. This covers:
- the reply values;
- how an armed command survives a non-arming command;
- how one arming command replaces another;
- which channel each data byte goes to;
- the decode of the 0xF0..0xFF range;
- the reset request raised through an output-port write.

// File: rtl/kbc_pkg.sv
package kbc_pkg;
    localparam int BYTE_W = 8;
    typedef logic [BYTE_W-1:0] byte_t;

    // Bit positions that other logic decodes
    localparam int MODE_AUX_OFF_BIT  = 5;
    localparam int MODE_KBD_OFF_BIT  = 4;
    localparam int STAT_SELFTEST_BIT = 2;
    localparam int OUTP_A20_BIT      = 1;
    localparam int OUTP_RUN_BIT      = 0;

    // Fixed reply values
    localparam byte_t RPL_SELFTEST_OK = 8'h55;
    localparam byte_t RPL_IF_OK       = 8'h00;
    localparam byte_t RPL_INPORT      = 8'h80;

    typedef enum logic [4:0] {
        ACT_NONE,
        ACT_READ_MODE,
        ACT_ARM_MODE,
        ACT_ARM_OUTP,
        ACT_ARM_KOBUF,
        ACT_ARM_AOBUF,
        ACT_ARM_MOUSE,
        ACT_AUX_OFF,
        ACT_AUX_ON,
        ACT_KBD_OFF,
        ACT_KBD_ON,
        ACT_SELFTEST,
        ACT_IF_TEST,
        ACT_READ_INPORT,
        ACT_READ_OUTP,
        ACT_A20_ON,
        ACT_A20_OFF,
        ACT_PULSE_RESET,
        ACT_PULSE_NOP,
        ACT_BAD
    } kbc_act_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT_MODE,
        ST_WAIT_OUTP,
        ST_WAIT_KOBUF,
        ST_WAIT_AOBUF,
        ST_WAIT_MOUSE
    } kbc_state_e;
endpackage

// File: rtl/kbc_cmd_decode.sv
module kbc_cmd_decode
    import kbc_pkg::*;
(
    input  byte_t    cmd,
    output kbc_act_e act
);
    localparam int HI_W = BYTE_W / 2;

    always_comb begin
        act = ACT_BAD;
        if (cmd[BYTE_W-1 -: HI_W] == {HI_W{1'b1}}) begin
            // pulse family: bit 0 selects reset (0) or nothing (1)
            act = cmd[0] ? ACT_PULSE_NOP : ACT_PULSE_RESET;
        end else begin
            unique case (cmd)
                8'h20:   act = ACT_READ_MODE;
                8'h60:   act = ACT_ARM_MODE;
                8'hA7:   act = ACT_AUX_OFF;
                8'hA8:   act = ACT_AUX_ON;
                8'hA9:   act = ACT_IF_TEST;
                8'hAA:   act = ACT_SELFTEST;
                8'hAB:   act = ACT_IF_TEST;
                8'hAD:   act = ACT_KBD_OFF;
                8'hAE:   act = ACT_KBD_ON;
                8'hC0:   act = ACT_READ_INPORT;
                8'hD0:   act = ACT_READ_OUTP;
                8'hD1:   act = ACT_ARM_OUTP;
                8'hD2:   act = ACT_ARM_KOBUF;
                8'hD3:   act = ACT_ARM_AOBUF;
                8'hD4:   act = ACT_ARM_MOUSE;
                8'hDD:   act = ACT_A20_OFF;
                8'hDF:   act = ACT_A20_ON;
                default: act = ACT_BAD;
            endcase
        end
    end
endmodule

// File: rtl/kbc_ctrl_regs.sv
module kbc_ctrl_regs
    import kbc_pkg::*;
#(
    parameter byte_t MODE_RST = 8'h03,
    parameter byte_t STAT_RST = 8'h18,
    parameter byte_t OUTP_RST = 8'hCF
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  mode_we,
    input  byte_t mode_nxt,
    input  logic  selftest_set,
    input  logic  outp_we,
    input  byte_t outp_nxt,
    output byte_t mode_q,
    output byte_t stat_q,
    output byte_t outp_q,
    output logic  a20_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= MODE_RST;
            stat_q <= STAT_RST;
            outp_q <= OUTP_RST;
            a20_q  <= OUTP_RST[OUTP_A20_BIT];
        end else begin
            if (mode_we) begin
                mode_q <= mode_nxt;
            end
            if (selftest_set) begin
                stat_q[STAT_SELFTEST_BIT] <= 1'b1;
            end
            if (outp_we) begin
                outp_q <= outp_nxt;
                a20_q  <= outp_nxt[OUTP_A20_BIT];
            end
        end
    end
endmodule

// File: rtl/kbc_cmd_proc.sv
module kbc_cmd_proc
    import kbc_pkg::*;
#(
    parameter byte_t MODE_RST = 8'h03,
    parameter byte_t STAT_RST = 8'h18,
    parameter byte_t OUTP_RST = 8'hCF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_we,
    input  logic              data_we,
    input  logic [BYTE_W-1:0] wr_byte,
    input  logic              rsp_ready,
    output logic              rsp_valid,
    output logic [BYTE_W-1:0] rsp_byte,
    output logic              rsp_aux,
    output logic              kbd_tx_valid,
    output logic [BYTE_W-1:0] kbd_tx_byte,
    output logic              aux_tx_valid,
    output logic [BYTE_W-1:0] aux_tx_byte,
    output logic [BYTE_W-1:0] mode_byte,
    output logic [BYTE_W-1:0] status_byte,
    output logic [BYTE_W-1:0] outport_byte,
    output logic              a20_gate,
    output logic              sys_reset_req,
    output logic              bad_cmd
);
    kbc_state_e state_q, state_d;
    kbc_act_e   act;

    logic  acc_cmd, acc_data;
    logic  mode_we, selftest_set, outp_we;
    byte_t mode_nxt, outp_nxt;
    byte_t mode_q, stat_q, outp_q;
    logic  a20_q;

    logic  rsp_v_d, rsp_aux_d, ktx_v_d, atx_v_d, srst_d, bad_d;
    byte_t rsp_b_d, ktx_b_d, atx_b_d;

    // The command port wins; a data write in the same cycle is dropped.
    assign acc_cmd  = cmd_we & rsp_ready;
    assign acc_data = data_we & ~cmd_we & rsp_ready;

    kbc_cmd_decode dec_i (
        .cmd (wr_byte),
        .act (act)
    );

    kbc_ctrl_regs #(
        .MODE_RST (MODE_RST),
        .STAT_RST (STAT_RST),
        .OUTP_RST (OUTP_RST)
    ) regs_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .mode_we      (mode_we),
        .mode_nxt     (mode_nxt),
        .selftest_set (selftest_set),
        .outp_we      (outp_we),
        .outp_nxt     (outp_nxt),
        .mode_q       (mode_q),
        .stat_q       (stat_q),
        .outp_q       (outp_q),
        .a20_q        (a20_q)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state and next outputs
    always_comb begin
        state_d      = state_q;
        mode_we      = 1'b0;
        mode_nxt     = mode_q;
        selftest_set = 1'b0;
        outp_we      = 1'b0;
        outp_nxt     = outp_q;
        rsp_v_d      = 1'b0;
        rsp_b_d      = '0;
        rsp_aux_d    = 1'b0;
        ktx_v_d      = 1'b0;
        ktx_b_d      = '0;
        atx_v_d      = 1'b0;
        atx_b_d      = '0;
        srst_d       = 1'b0;
        bad_d        = 1'b0;

        if (acc_cmd) begin
            unique case (act)
                ACT_READ_MODE: begin
                    rsp_v_d = 1'b1;
                    rsp_b_d = mode_q;
                end
                ACT_ARM_MODE:  state_d = ST_WAIT_MODE;
                ACT_ARM_OUTP:  state_d = ST_WAIT_OUTP;
                ACT_ARM_KOBUF: state_d = ST_WAIT_KOBUF;
                ACT_ARM_AOBUF: state_d = ST_WAIT_AOBUF;
                ACT_ARM_MOUSE: state_d = ST_WAIT_MOUSE;
                ACT_AUX_OFF: begin
                    mode_we                    = 1'b1;
                    mode_nxt[MODE_AUX_OFF_BIT] = 1'b1;
                end
                ACT_AUX_ON: begin
                    mode_we                    = 1'b1;
                    mode_nxt[MODE_AUX_OFF_BIT] = 1'b0;
                end
                ACT_KBD_OFF: begin
                    mode_we                    = 1'b1;
                    mode_nxt[MODE_KBD_OFF_BIT] = 1'b1;
                end
                ACT_KBD_ON: begin
                    mode_we                    = 1'b1;
                    mode_nxt[MODE_KBD_OFF_BIT] = 1'b0;
                end
                ACT_SELFTEST: begin
                    selftest_set = 1'b1;
                    rsp_v_d      = 1'b1;
                    rsp_b_d      = RPL_SELFTEST_OK;
                end
                ACT_IF_TEST: begin
                    rsp_v_d = 1'b1;
                    rsp_b_d = RPL_IF_OK;
                end
                ACT_READ_INPORT: begin
                    rsp_v_d = 1'b1;
                    rsp_b_d = RPL_INPORT;
                end
                ACT_READ_OUTP: begin
                    rsp_v_d = 1'b1;
                    rsp_b_d = outp_q;
                end
                ACT_A20_ON: begin
                    outp_we                = 1'b1;
                    outp_nxt[OUTP_A20_BIT] = 1'b1;
                end
                ACT_A20_OFF: begin
                    outp_we                = 1'b1;
                    outp_nxt[OUTP_A20_BIT] = 1'b0;
                end
                ACT_PULSE_RESET: srst_d = 1'b1;
                ACT_PULSE_NOP:   ;
                ACT_BAD:         bad_d  = 1'b1;
                default:         ;
            endcase
        end else if (acc_data) begin
            state_d = ST_IDLE;
            unique case (state_q)
                ST_IDLE: begin
                    ktx_v_d = 1'b1;
                    ktx_b_d = wr_byte;
                end
                ST_WAIT_MODE: begin
                    mode_we  = 1'b1;
                    mode_nxt = wr_byte;
                end
                ST_WAIT_OUTP: begin
                    outp_we  = 1'b1;
                    outp_nxt = wr_byte;
                    srst_d   = ~wr_byte[OUTP_RUN_BIT];
                end
                ST_WAIT_KOBUF: begin
                    rsp_v_d = 1'b1;
                    rsp_b_d = wr_byte;
                end
                ST_WAIT_AOBUF: begin
                    rsp_v_d   = 1'b1;
                    rsp_b_d   = wr_byte;
                    rsp_aux_d = 1'b1;
                end
                ST_WAIT_MOUSE: begin
                    atx_v_d = 1'b1;
                    atx_b_d = wr_byte;
                end
                default: ;
            endcase
        end
    end

    // Registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_valid     <= 1'b0;
            rsp_byte      <= '0;
            rsp_aux       <= 1'b0;
            kbd_tx_valid  <= 1'b0;
            kbd_tx_byte   <= '0;
            aux_tx_valid  <= 1'b0;
            aux_tx_byte   <= '0;
            sys_reset_req <= 1'b0;
            bad_cmd       <= 1'b0;
        end else begin
            rsp_valid     <= rsp_v_d;
            rsp_byte      <= rsp_b_d;
            rsp_aux       <= rsp_aux_d;
            kbd_tx_valid  <= ktx_v_d;
            kbd_tx_byte   <= ktx_b_d;
            aux_tx_valid  <= atx_v_d;
            aux_tx_byte   <= atx_b_d;
            sys_reset_req <= srst_d;
            bad_cmd       <= bad_d;
        end
    end

    assign mode_byte    = mode_q;
    assign status_byte  = stat_q;
    assign outport_byte = outp_q;
    assign a20_gate     = a20_q;
endmodule

// File: rtl/kbc_cmd_proc_chk.sv
module kbc_cmd_proc_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cmd_we,
    input logic       data_we,
    input logic       rsp_ready,
    input logic       rsp_valid,
    input logic       kbd_tx_valid,
    input logic       aux_tx_valid,
    input logic [7:0] mode_byte,
    input logic [7:0] status_byte,
    input logic [7:0] outport_byte,
    input logic       a20_gate,
    input logic       sys_reset_req,
    input logic       bad_cmd
);
    // R12
    one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rsp_valid, kbd_tx_valid, aux_tx_valid, sys_reset_req, bad_cmd}));

    // R2
    reply_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(rsp_ready && (cmd_we || data_we)));

    // R2
    refused_mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_ready |=> $stable(mode_byte));

    // R8
    a20_tracks_outport_chk: assert property (@(posedge clk) disable iff (!rst_n)
        a20_gate == outport_byte[1]);

    // R10
    reset_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sys_reset_req |-> $past(rsp_ready && (cmd_we || data_we)));

    // R4
    selftest_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(status_byte[2]) |-> status_byte[2]);
endmodule

bind kbc_cmd_proc kbc_cmd_proc_chk chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .cmd_we        (cmd_we),
    .data_we       (data_we),
    .rsp_ready     (rsp_ready),
    .rsp_valid     (rsp_valid),
    .kbd_tx_valid  (kbd_tx_valid),
    .aux_tx_valid  (aux_tx_valid),
    .mode_byte     (mode_byte),
    .status_byte   (status_byte),
    .outport_byte  (outport_byte),
    .a20_gate      (a20_gate),
    .sys_reset_req (sys_reset_req),
    .bad_cmd       (bad_cmd)
);

// File: tb/kbc_cmd_proc_tb_top.sv
module kbc_cmd_proc_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_we = 1'b0;
    logic       data_we = 1'b0;
    logic [7:0] wr_byte = 8'h00;
    logic       rsp_ready = 1'b1;
    logic       rsp_valid, rsp_aux, kbd_tx_valid, aux_tx_valid;
    logic [7:0] rsp_byte, kbd_tx_byte, aux_tx_byte;
    logic [7:0] mode_byte, status_byte, outport_byte;
    logic       a20_gate, sys_reset_req, bad_cmd;

    int n_checks = 0;
    int n_err    = 0;
    bit done     = 1'b0;

    // reference model state
    int m_mode = 8'h03, m_stat = 8'h18, m_outp = 8'hCF, m_a20 = 1, m_pend = 0;
    int e_rv = 0, e_rb = 0, e_ra = 0, e_kv = 0, e_kb = 0, e_av = 0, e_ab = 0;
    int e_sr = 0, e_bad = 0;

    always #10 clk = ~clk;

    kbc_cmd_proc dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .cmd_we        (cmd_we),
        .data_we       (data_we),
        .wr_byte       (wr_byte),
        .rsp_ready     (rsp_ready),
        .rsp_valid     (rsp_valid),
        .rsp_byte      (rsp_byte),
        .rsp_aux       (rsp_aux),
        .kbd_tx_valid  (kbd_tx_valid),
        .kbd_tx_byte   (kbd_tx_byte),
        .aux_tx_valid  (aux_tx_valid),
        .aux_tx_byte   (aux_tx_byte),
        .mode_byte     (mode_byte),
        .status_byte   (status_byte),
        .outport_byte  (outport_byte),
        .a20_gate      (a20_gate),
        .sys_reset_req (sys_reset_req),
        .bad_cmd       (bad_cmd)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic reply(input int b, input int aux);
        e_rv = 1; e_rb = b; e_ra = aux;
    endtask

    task automatic model_step(input bit c, input bit d, input int b, input bit rdy);
        e_rv = 0; e_ra = 0; e_kv = 0; e_av = 0; e_sr = 0; e_bad = 0;
        if (!rdy) return;
        if (c) begin
            if (b >= 8'hF0) begin
                if (b % 2 == 0) e_sr = 1;
            end else if (b == 8'h20) reply(m_mode, 0);
            else if (b == 8'h60 || b == 8'hD1 || b == 8'hD2 || b == 8'hD3 || b == 8'hD4)
                m_pend = b;
            else if (b == 8'hA7) m_mode = m_mode | 8'h20;
            else if (b == 8'hA8) m_mode = m_mode & 8'hDF;
            else if (b == 8'hAD) m_mode = m_mode | 8'h10;
            else if (b == 8'hAE) m_mode = m_mode & 8'hEF;
            else if (b == 8'hAA) begin m_stat = m_stat | 4; reply(8'h55, 0); end
            else if (b == 8'hA9 || b == 8'hAB) reply(0, 0);
            else if (b == 8'hC0) reply(8'h80, 0);
            else if (b == 8'hD0) reply(m_outp, 0);
            else if (b == 8'hDF) begin m_outp = m_outp | 2; m_a20 = 1; end
            else if (b == 8'hDD) begin m_outp = m_outp & 8'hFD; m_a20 = 0; end
            else e_bad = 1;
        end else if (d) begin
            if (m_pend == 0) begin e_kv = 1; e_kb = b; end
            else if (m_pend == 8'h60) m_mode = b;
            else if (m_pend == 8'hD2) reply(b, 0);
            else if (m_pend == 8'hD3) reply(b, 1);
            else if (m_pend == 8'hD4) begin e_av = 1; e_ab = b; end
            else if (m_pend == 8'hD1) begin
                m_outp = b; m_a20 = (b / 2) % 2;
                if (b % 2 == 0) e_sr = 1;
            end
            m_pend = 0;
        end
    endtask

    task automatic compare_all(input string tag);
        chk(tag, "rsp_valid", int'(rsp_valid), e_rv);
        if (e_rv != 0) begin
            chk(tag, "rsp_byte", int'(rsp_byte), e_rb);
            chk(tag, "rsp_aux", int'(rsp_aux), e_ra);
        end
        chk(tag, "kbd_tx_valid", int'(kbd_tx_valid), e_kv);
        if (e_kv != 0) chk(tag, "kbd_tx_byte", int'(kbd_tx_byte), e_kb);
        chk(tag, "aux_tx_valid", int'(aux_tx_valid), e_av);
        if (e_av != 0) chk(tag, "aux_tx_byte", int'(aux_tx_byte), e_ab);
        chk(tag, "sys_reset_req", int'(sys_reset_req), e_sr);
        chk(tag, "bad_cmd", int'(bad_cmd), e_bad);
        chk(tag, "mode", int'(mode_byte), m_mode);
        chk(tag, "status", int'(status_byte), m_stat);
        chk(tag, "outport", int'(outport_byte), m_outp);
        chk(tag, "a20", int'(a20_gate), m_a20);
        // R12: strobes exclusive
        chk("R12", "strobe count>1",
            int'(($countones({rsp_valid, kbd_tx_valid, aux_tx_valid, sys_reset_req, bad_cmd})) > 1), 0);
    endtask

    // One clock: drive at negedge, model at posedge, compare at next negedge
    task automatic drive(input string tag, input bit c, input bit d, input int b, input bit rdy);
        cmd_we = c; data_we = d; wr_byte = 8'(b); rsp_ready = rdy;
        @(posedge clk);
        model_step(c, d, b, rdy);
        @(negedge clk);
        cmd_we = 1'b0; data_we = 1'b0; rsp_ready = 1'b1;
        compare_all(tag);
    endtask

    task automatic cmd(input string tag, input int b);
        drive(tag, 1'b1, 1'b0, b, 1'b1);
    endtask

    task automatic dat(input string tag, input int b);
        drive(tag, 1'b0, 1'b1, b, 1'b1);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset values
        chk("R1", "mode", int'(mode_byte), 8'h03);
        chk("R1", "status", int'(status_byte), 8'h18);
        chk("R1", "outport", int'(outport_byte), 8'hCF);
        chk("R1", "a20", int'(a20_gate), 1);
        chk("R1", "strobes", int'({rsp_valid, kbd_tx_valid, aux_tx_valid, sys_reset_req, bad_cmd}), 0);
        drive("R1 idle", 1'b0, 1'b0, 0, 1'b1);

        // R2 refused writes and command priority
        drive("R2 refused cmd", 1'b1, 1'b0, 8'hAA, 1'b0);
        drive("R2 refused data", 1'b0, 1'b1, 8'h12, 1'b0);
        drive("R2 refused arm", 1'b1, 1'b0, 8'h60, 1'b0);
        dat("R2 data after refused arm", 8'h34);
        drive("R2 cmd wins", 1'b1, 1'b1, 8'h20, 1'b1);

        // R3 reads
        cmd("R3 read mode", 8'h20);
        cmd("R3 read outport", 8'hD0);

        // R4 fixed replies
        cmd("R4 self test", 8'hAA);
        cmd("R4 mouse if test", 8'hA9);
        cmd("R4 kbd if test", 8'hAB);
        cmd("R4 input port", 8'hC0);
        cmd("R4 self test again", 8'hAA);

        // R5 disable bits
        cmd("R5 aux off", 8'hA7);
        cmd("R5 read", 8'h20);
        cmd("R5 kbd off", 8'hAD);
        cmd("R5 aux on", 8'hA8);
        cmd("R5 kbd on", 8'hAE);
        cmd("R5 read", 8'h20);

        // R6 arming: survives non-arming, replaced by arming
        cmd("R6 arm mode", 8'h60);
        cmd("R6 non-arming", 8'hA9);
        dat("R6 mode load", 8'h47);
        cmd("R6 read", 8'h20);
        cmd("R6 arm mode", 8'h60);
        cmd("R6 rearm kbd obuf", 8'hD2);
        dat("R6 kbd reply", 8'h9C);

        // R7 data routing
        cmd("R7 arm aux obuf", 8'hD3);
        dat("R7 aux reply", 8'h33);
        cmd("R7 arm mouse", 8'hD4);
        dat("R7 mouse tx", 8'h44);
        dat("R7 kbd tx", 8'h5A);
        dat("R7 kbd tx b2b", 8'hED);
        cmd("R7 arm mode", 8'h60);
        dat("R7 restore mode", 8'h03);

        // R8 output port writes
        cmd("R8 arm outport", 8'hD1);
        dat("R8 a20 low no reset", 8'hCD);
        cmd("R8 arm outport", 8'hD1);
        dat("R8 reset request", 8'hCE);
        drive("R8 pulse ends", 1'b0, 1'b0, 0, 1'b1);
        cmd("R8 read outport", 8'hD0);
        cmd("R8 arm outport", 8'hD1);
        dat("R8 restore", 8'hCF);

        // R9 A20 commands
        cmd("R9 a20 off", 8'hDD);
        cmd("R9 read", 8'hD0);
        cmd("R9 a20 on", 8'hDF);

        // R10 pulse family
        cmd("R10 FE", 8'hFE);
        cmd("R10 FE b2b", 8'hFE);
        cmd("R10 FF", 8'hFF);
        cmd("R10 F0", 8'hF0);
        cmd("R10 F1", 8'hF1);
        cmd("R10 FC", 8'hFC);

        // R11 unknown commands
        cmd("R11 00", 8'h00);
        cmd("R11 5B", 8'h5B);
        cmd("R11 B7", 8'hB7);
        cmd("R11 read", 8'h20);

        repeat (3) drive("R12 idle", 1'b0, 1'b0, 0, 1'b1);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end
endmodule